// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the status byte and ready/busy signal that a NOR-style flash memory shows while an internal program or erase runs. It accepts decoded commands (program, sector erase, chip erase, erase suspend, erase resume and reset), each with an address. It also takes the array data from the storage behind it, a one-microsecond tick and a read strobe with a read address. While no operation is active, reads pass the array data through unchanged. While an operation is active, the read data carries a complemented data bit, two read-driven toggle bits, a timeout flag and an erase-started flag.

Operation length is a stand-in: cycle counters with parameterised durations take the place of real program and erase timing. A parameterised limit on each operation, or a test input, puts the block into a halted state. Only a reset command leaves that state. A sector erase first opens an acceptance window counted in microsecond ticks. Every further sector-erase command inside the window adds its sector to the erase set and restarts the window. A chip erase starts at once with every sector selected.

Top module: `flash_status_gen`

## Requirements
- R1: When no operation is active (after reset, after normal completion, or after a reset command in the halted state), read data equals `array_data` and `ready` is 1.
- R2: During a program, a read at the programmed address returns bit 7 = complement of `cmd_data7`, and a read at any other address returns bit 7 = 0. Bits 5 and 3 read 0 and `ready` is 0.
- R3: While a program, erase window, erase or halted operation is active, bit 6 changes value on every read. During a program, bit 2 does not change between reads.
- R4: A sector-erase command (`cmd_op`=2) from idle opens an acceptance window with bit 3 = 0 and `ready` = 0. After `WINDOW_US` ticks of `us_tick` with no further sector-erase command, the erase starts and bit 3 reads 1.
- R5: A sector-erase command inside the window adds the sector `cmd_addr[ADDR_W-1:SECTOR_SHIFT]` to the erase set and restarts the full window.
- R6: Once the erase has started, every command other than erase-suspend (`cmd_op`=4) is ignored. A chip-erase command (`cmd_op`=3) starts the erase at once with bit 3 = 1 and all sectors selected.
- R7: During an erase, bit 7 reads 0. Bit 2 changes on reads whose address lies in a selected sector and holds on reads of other sectors.
- R8: While erase is suspended, a read of a selected sector returns bit 7 = 1 and `ready` = 1. Bit 6 holds and bit 2 changes. A read of any other sector returns `array_data` with `ready` = 1.
- R9: A program command (`cmd_op`=1) to a non-selected sector while suspended gives program status (bit 7 = complement of the data at its address, bit 6 changing, `ready` = 0) and returns to the suspended state when done. Resume (`cmd_op`=5) continues the erase to completion.
- R10: When an operation reaches `TIMEOUT_CYCLES` or `force_timeout` is 1, the block halts with bit 5 = 1 and `ready` = 0. It stays halted until a reset command (`cmd_op`=6).
- R11: A program ends exactly `PROG_CYCLES` clock cycles after its command is taken. An erase ends after `ERASE_CYCLES` cycles of running time, and suspended time does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command code: 1 program, 2 sector erase, 3 chip erase, 4 suspend, 5 resume, 6 reset |
| cmd_addr | input | ADDR_W | Command address (sector or program address) |
| cmd_data7 | input | 1 | Most significant bit of the data being programmed |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| force_timeout | input | 1 | Test input that forces the active operation to time out |
| rd_en | input | 1 | Read strobe; toggle bits advance on each strobe |
| rd_addr | input | ADDR_W | Read address |
| array_data | input | 8 | Data from the storage array at rd_addr |
| rd_data | output | 8 | Status byte or array data |
| ready | output | 1 | 1 = ready, 0 = busy |

## Verification
The bench builds the block with an 8-bit address split into sixteen 16-byte sectors and a window of 3 ticks. This lets the restart of the acceptance window be checked tick by tick. A program length of 10 cycles, an erase length of 40 cycles and a limit of 60 cycles make the exact completion edge of a program easy to check. They also leave enough erase time to walk through suspend, program-while-suspended and resume before the erase ends. Timeouts are reached through the force input, so both the halted-program and halted-erase encodings can be checked at known addresses.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

   typedef enum logic [2:0] {
      OP_NOP        = 3'd0,
      OP_PROGRAM    = 3'd1,
      OP_SECT_ERASE = 3'd2,
      OP_CHIP_ERASE = 3'd3,
      OP_SUSPEND    = 3'd4,
      OP_RESUME     = 3'd5,
      OP_RESET      = 3'd6
   } cmd_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PROG,
      ST_WINDOW,
      ST_ERASE,
      ST_SUSP,
      ST_SUSP_PROG,
      ST_HALTED
   } op_state_e;

endpackage

// File: rtl/fsg_accept_window.sv
module fsg_accept_window #(
   parameter int WINDOW_US = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic active,
   input  logic us_tick,
   output logic expire
);
   localparam int CW = $clog2(WINDOW_US + 1);

   generate
      if (WINDOW_US < 1) begin : g_bad_window
         $error("WINDOW_US must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign expire = active && !restart && us_tick && (cnt_q == CW'(WINDOW_US - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart)
         cnt_q <= '0;
      else if (active && us_tick)
         cnt_q <= cnt_q + 1'b1;
   end

   AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n) active |-> (cnt_q < CW'(WINDOW_US))); // R4
   AST_WIN_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (restart && active) |=> !expire); // R5

endmodule

// File: rtl/fsg_op_timer.sv
module fsg_op_timer #(
   parameter int DURATION = 16,
   parameter int LIMIT    = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   input  logic force_tmo,
   output logic done,
   output logic tmo_hit
);
   localparam int MAXV = (DURATION > LIMIT) ? DURATION : LIMIT;
   localparam int CW   = $clog2(MAXV + 1);

   generate
      if (DURATION < 1) begin : g_bad_dur
         $error("DURATION must be at least 1");
      end
      if (LIMIT < 1) begin : g_bad_lim
         $error("LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign tmo_hit = run && (force_tmo || (cnt_q == CW'(LIMIT - 1)));
   assign done    = run && !tmo_hit && (cnt_q == CW'(DURATION - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start)
         cnt_q <= '0;
      else if (run && cnt_q != CW'(MAXV))
         cnt_q <= cnt_q + 1'b1;
   end

   AST_OP_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) start |=> (cnt_q == '0)); // R11
   AST_OP_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!run && !start) |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/fsg_status_mux.sv
module fsg_status_mux
   import fsg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  op_state_e  state,
   input  logic       rd_en,
   input  logic       sel_hit,
   input  logic       addr_hit,
   input  logic       prog_d7,
   input  logic       halt_prog,
   input  logic [7:0] array_data,
   output logic [7:0] rd_data,
   output logic       ready
);
   logic tog6_q, tog2_q;
   logic flip6, flip2;

   always_comb begin
      rd_data = 8'h00;
      ready   = 1'b0;
      flip6   = 1'b0;
      flip2   = 1'b0;
      case (state)
         ST_PROG, ST_SUSP_PROG: begin
            rd_data[7] = addr_hit & ~prog_d7;
            rd_data[6] = tog6_q;
            rd_data[2] = tog2_q;
            flip6      = 1'b1;
         end
         ST_WINDOW, ST_ERASE: begin
            rd_data[6] = tog6_q;
            rd_data[3] = (state == ST_ERASE);
            rd_data[2] = tog2_q;
            flip6      = 1'b1;
            flip2      = sel_hit;
         end
         ST_SUSP: begin
            ready = 1'b1;
            if (sel_hit) begin
               rd_data[7] = 1'b1;
               rd_data[6] = tog6_q;
               rd_data[2] = tog2_q;
               flip2      = 1'b1;
            end else begin
               rd_data = array_data;
            end
         end
         ST_HALTED: begin
            rd_data[7] = halt_prog & addr_hit & ~prog_d7;
            rd_data[6] = tog6_q;
            rd_data[5] = 1'b1;
            rd_data[3] = ~halt_prog;
            rd_data[2] = tog2_q;
            flip6      = 1'b1;
            flip2      = ~halt_prog & sel_hit;
         end
         default: begin
            rd_data = array_data;
            ready   = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog6_q <= 1'b0;
         tog2_q <= 1'b0;
      end else if (rd_en) begin
         tog6_q <= tog6_q ^ flip6;
         tog2_q <= tog2_q ^ flip2;
      end
   end

   AST_TOG6_ACTIVE_FLIP: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && state inside {ST_PROG, ST_WINDOW, ST_ERASE, ST_HALTED}) |=> (tog6_q != $past(tog6_q))); // R3
   AST_TOG2_PROG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_PROG) |=> $stable(tog2_q)); // R3
   AST_TOG6_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_SUSP) |=> $stable(tog6_q)); // R8

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
   import fsg_pkg::*;
#(
   parameter int ADDR_W         = 16,
   parameter int SECTOR_SHIFT   = 12,
   parameter int WINDOW_US      = 50,
   parameter int PROG_CYCLES    = 16,
   parameter int ERASE_CYCLES   = 256,
   parameter int TIMEOUT_CYCLES = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              cmd_data7,
   input  logic              us_tick,
   input  logic              force_timeout,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        array_data,
   output logic [7:0]        rd_data,
   output logic              ready
);
   localparam int SECT_W = ADDR_W - SECTOR_SHIFT;
   localparam int NSECT  = 1 << SECT_W;

   generate
      if (SECTOR_SHIFT < 1 || SECT_W < 1 || SECT_W > 10) begin : g_bad_geom
         $error("sector geometry must give 2 to 1024 sectors");
      end
   endgenerate

   op_state_e st_q, st_d;
   logic [ADDR_W-1:0] prog_addr_q;
   logic              prog_d7_q, halt_prog_q;
   logic [NSECT-1:0]  sel_q;

   logic [SECT_W-1:0] cmd_sect, rd_sect;
   logic is_prog, is_se, is_ce, is_susp, is_res, is_rst;
   logic prog_load, pg_start, er_start, win_restart;
   logic sel_load, sel_all, sel_add, halt_set, halt_as_prog;
   logic pg_done, pg_tmo, er_done, er_tmo, win_expire;

   assign cmd_sect = cmd_addr[ADDR_W-1:SECTOR_SHIFT];
   assign rd_sect  = rd_addr[ADDR_W-1:SECTOR_SHIFT];

   assign is_prog = cmd_valid && (cmd_op == OP_PROGRAM);
   assign is_se   = cmd_valid && (cmd_op == OP_SECT_ERASE);
   assign is_ce   = cmd_valid && (cmd_op == OP_CHIP_ERASE);
   assign is_susp = cmd_valid && (cmd_op == OP_SUSPEND);
   assign is_res  = cmd_valid && (cmd_op == OP_RESUME);
   assign is_rst  = cmd_valid && (cmd_op == OP_RESET);

   // operation sequencing
   always_comb begin
      st_d         = st_q;
      prog_load    = 1'b0;
      pg_start     = 1'b0;
      er_start     = 1'b0;
      win_restart  = 1'b0;
      sel_load     = 1'b0;
      sel_all      = 1'b0;
      sel_add      = 1'b0;
      halt_set     = 1'b0;
      halt_as_prog = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (is_prog) begin
               st_d = ST_PROG; prog_load = 1'b1; pg_start = 1'b1;
            end else if (is_se) begin
               st_d = ST_WINDOW; sel_load = 1'b1; win_restart = 1'b1;
            end else if (is_ce) begin
               st_d = ST_ERASE; sel_load = 1'b1; sel_all = 1'b1; er_start = 1'b1;
            end
         end
         ST_PROG, ST_SUSP_PROG: begin
            if (pg_tmo) begin
               st_d = ST_HALTED; halt_set = 1'b1; halt_as_prog = 1'b1;
            end else if (pg_done) begin
               st_d = (st_q == ST_PROG) ? ST_IDLE : ST_SUSP;
            end
         end
         ST_WINDOW: begin
            if (is_se) begin
               sel_add = 1'b1; win_restart = 1'b1;
            end else if (win_expire) begin
               st_d = ST_ERASE; er_start = 1'b1;
            end
         end
         ST_ERASE: begin
            if (er_tmo) begin
               st_d = ST_HALTED; halt_set = 1'b1;
            end else if (er_done) begin
               st_d = ST_IDLE;
            end else if (is_susp) begin
               st_d = ST_SUSP;
            end
         end
         ST_SUSP: begin
            if (is_res) begin
               st_d = ST_ERASE;
            end else if (is_prog && !sel_q[cmd_sect]) begin
               st_d = ST_SUSP_PROG; prog_load = 1'b1; pg_start = 1'b1;
            end
         end
         ST_HALTED: begin
            if (is_rst) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         prog_addr_q <= '0;
         prog_d7_q   <= 1'b0;
         halt_prog_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (prog_load) begin
            prog_addr_q <= cmd_addr;
            prog_d7_q   <= cmd_data7;
         end
         if (halt_set) halt_prog_q <= halt_as_prog;
      end
   end

   // erase sector set, one flag per sector
   genvar gs;
   generate
      for (gs = 0; gs < NSECT; gs++) begin : g_sect
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sel_q[gs] <= 1'b0;
            else if (sel_load)
               sel_q[gs] <= sel_all || (cmd_sect == SECT_W'(gs));
            else if (sel_add && cmd_sect == SECT_W'(gs))
               sel_q[gs] <= 1'b1;
         end
      end
   endgenerate

   fsg_accept_window #(.WINDOW_US(WINDOW_US)) u_window (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (win_restart),
      .active  (st_q == ST_WINDOW),
      .us_tick (us_tick),
      .expire  (win_expire)
   );

   fsg_op_timer #(.DURATION(PROG_CYCLES), .LIMIT(TIMEOUT_CYCLES)) u_prog_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (pg_start),
      .run       (st_q == ST_PROG || st_q == ST_SUSP_PROG),
      .force_tmo (force_timeout),
      .done      (pg_done),
      .tmo_hit   (pg_tmo)
   );

   fsg_op_timer #(.DURATION(ERASE_CYCLES), .LIMIT(TIMEOUT_CYCLES)) u_erase_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (er_start),
      .run       (st_q == ST_ERASE),
      .force_tmo (force_timeout),
      .done      (er_done),
      .tmo_hit   (er_tmo)
   );

   fsg_status_mux u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .state      (st_q),
      .rd_en      (rd_en),
      .sel_hit    (sel_q[rd_sect]),
      .addr_hit   (rd_addr == prog_addr_q),
      .prog_d7    (prog_d7_q),
      .halt_prog  (halt_prog_q),
      .array_data (array_data),
      .rd_data    (rd_data),
      .ready      (ready)
   );

   AST_ERASE_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_ERASE && cmd_valid && cmd_op != OP_SUSPEND && !er_done && !er_tmo) |=> (st_q == ST_ERASE)); // R6
   AST_CHIP_SKIPS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_IDLE && is_ce) |=> (st_q == ST_ERASE && (&sel_q))); // R6
   AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_HALTED && !is_rst) |=> (st_q == ST_HALTED && !ready)); // R10
   AST_SUSP_READY: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_SUSP) |-> ready); // R8
   AST_WINDOW_ADDS: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_WINDOW && is_se) |=> (st_q == ST_WINDOW && sel_q[$past(cmd_sect)])); // R5

endmodule

// File: tb/flash_status_gen_test.sv
module flash_status_gen_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW   = 8;
   localparam int PROG = 10;
   localparam int ERS  = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_op = 3'd0;
   logic [AW-1:0] cmd_addr = '0;
   logic       cmd_data7 = 1'b0;
   logic       us_tick = 1'b0;
   logic       force_timeout = 1'b0;
   logic       rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0] array_data = 8'hC3;
   logic [7:0] rd_data;
   logic       ready;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_status_gen #(
      .ADDR_W(AW), .SECTOR_SHIFT(4), .WINDOW_US(3),
      .PROG_CYCLES(PROG), .ERASE_CYCLES(ERS), .TIMEOUT_CYCLES(60)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data7(cmd_data7), .us_tick(us_tick),
      .force_timeout(force_timeout), .rd_en(rd_en), .rd_addr(rd_addr),
      .array_data(array_data), .rd_data(rd_data), .ready(ready)
   );

   // program vectors: {address, data}
   localparam logic [15:0] PVEC [4] = '{16'h05_80, 16'h47_3C, 16'hA2_FF, 16'hE9_01};

   task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic cmd(input logic [2:0] op, input logic [AW-1:0] a, input logic d7);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data7 = d7;
      @(posedge clk); @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic r);
      rd_en = 1'b1; rd_addr = a;
      #1; d = rd_data; r = ready;
      @(posedge clk); @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic tick();
      us_tick = 1'b1;
      @(posedge clk); @(negedge clk);
      us_tick = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d, d2;
      logic r, r2;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      rd(8'h33, d, r);
      chk(d == 8'hC3 && r, "R1 reset passthrough", d, 8'hC3);

      // table of program operations
      for (int i = 0; i < 4; i++) begin
         logic [7:0] pa, pd;
         pa = PVEC[i][15:8]; pd = PVEC[i][7:0];
         array_data = pd ^ 8'h5A;
         cmd(3'd1, pa, pd[7]);
         rd(pa, d, r);
         rd(pa, d2, r2);
         chk(d[7] == ~pd[7] && d[5] == 1'b0 && d[3] == 1'b0 && !r, "R2 program status at address", d, {~pd[7], 7'h00});
         chk(d[6] != d2[6] && d[2] == d2[2], "R3 program toggles", d2, d ^ 8'h40);
         rd(pa ^ 8'h01, d, r);
         chk(d[7] == 1'b0 && !r, "R2 program bit7 elsewhere", d, 8'h00);
         idle(PROG - 4);
         chk(!ready, "R11 program busy one cycle before end", {7'h0, ready}, 8'h00);
         idle(1);
         chk(ready, "R11 program ends on time", {7'h0, ready}, 8'h01);
         rd(pa, d, r);
         chk(d == (pd ^ 8'h5A) && r, "R1 array data after program", d, pd ^ 8'h5A);
      end

      // sector erase with window restart
      array_data = 8'h96;
      cmd(3'd2, 8'h10, 1'b0);
      rd(8'h15, d, r);
      chk(d[3] == 1'b0 && d[7] == 1'b0 && !r, "R4 window open", d, 8'h00);
      tick(); tick();
      cmd(3'd2, 8'h30, 1'b0);
      tick(); tick();
      rd(8'h15, d, r);
      chk(d[3] == 1'b0 && !r, "R5 window restarted", d, 8'h00);
      tick();
      rd(8'h15, d, r);
      chk(d[3] == 1'b1 && !r, "R4 erase started", d, 8'h08);

      rd(8'h31, d, r); rd(8'h31, d2, r2);
      chk(d[2] != d2[2] && d[6] != d2[6] && d2[7] == 1'b0, "R7 bit2 toggles in added sector", d2, d ^ 8'h44);
      rd(8'h20, d, r); rd(8'h20, d2, r2);
      chk(d[2] == d2[2], "R7 bit2 holds outside erase set", d2, d);

      cmd(3'd1, 8'h22, 1'b1);
      cmd(3'd6, 8'h00, 1'b0);
      cmd(3'd2, 8'h20, 1'b0);
      rd(8'h21, d, r); rd(8'h21, d2, r2);
      chk(d2[3] && !r2 && d[2] == d2[2], "R6 commands ignored during erase", d2, d);

      cmd(3'd4, 8'h00, 1'b0);
      rd(8'h12, d, r); rd(8'h12, d2, r2);
      chk(d[7] && r && d[5] == 1'b0, "R8 suspended sector status", d, 8'h80);
      chk(d[6] == d2[6] && d[2] != d2[2], "R8 suspended toggles", d2, d ^ 8'h04);
      rd(8'h40, d, r);
      chk(d == 8'h96 && r, "R8 other sector reads array", d, 8'h96);

      cmd(3'd1, 8'h45, 1'b0);
      rd(8'h45, d, r); rd(8'h45, d2, r2);
      chk(d[7] == 1'b1 && d[6] != d2[6] && !r, "R9 suspend-program status", d, 8'hC0);
      idle(PROG + 2);
      rd(8'h12, d, r);
      chk(d[7] && r, "R9 back to suspend", d, 8'h80);
      cmd(3'd5, 8'h00, 1'b0);
      rd(8'h12, d, r);
      chk(d[3] && !r, "R9 resume continues erase", d, 8'h08);
      idle(ERS + 5);
      rd(8'h12, d, r);
      chk(d == 8'h96 && r, "R11 erase completes after resume", d, 8'h96);

      // chip erase, then forced timeout
      cmd(3'd3, 8'h00, 1'b0);
      rd(8'hF0, d, r); rd(8'hF0, d2, r2);
      chk(d[3] && !r && d[2] != d2[2], "R6 chip erase skips window", d2, d ^ 8'h04);
      force_timeout = 1'b1; idle(1); force_timeout = 1'b0;
      rd(8'hF0, d, r);
      chk(d[5] && d[3] && !r, "R10 erase timeout flag", d, 8'h28);
      cmd(3'd1, 8'h11, 1'b1);
      idle(70);
      rd(8'hF0, d, r);
      chk(d[5] && !r, "R10 halted until reset", d, 8'h20);
      cmd(3'd6, 8'h00, 1'b0);
      rd(8'hF0, d, r);
      chk(d == 8'h96 && r, "R1 array data after reset command", d, 8'h96);

      // program timeout
      cmd(3'd1, 8'h22, 1'b0);
      force_timeout = 1'b1; idle(1); force_timeout = 1'b0;
      rd(8'h22, d, r);
      chk(d[5] && d[7] && !r, "R10 program timeout status", d, 8'hA0);
      cmd(3'd6, 8'h00, 1'b0);
      chk(ready, "R10 reset leaves halt", {7'h0, ready}, 8'h01);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule